// File: doc/BRIEF.md
# Interrupt level delivery pipeline

This block holds the interrupt enable and request registers of a chip and combines them into a pending set. It drives the highest pending priority level onto three active-low level pins for a 68000-style CPU. It also models the CPU side: the pins are latched on bus cycles, and the take-interrupt decision is made at instruction boundaries.

The path from a newly raised source to the pins is slowed on purpose. A newly raised source bit is hidden for a programmable number of colour-clock ticks before the encoder sees it. Acknowledges and mask writes still show up on the pins one clock later. The ports source is level-fed, so re-enabling it while it is already latched also shows up one clock later. The request register readback is never delayed. When the delay is programmed to zero, the hiding stops and the boundary decision uses the live pin level.

Top module: `irq_ipl_pipe`

## Requirements
- R1: After reset, both registers are zero, `ipl_n_o` is 3'b111, `take_o` is 0 and `take_lvl_o` is 0.
- R2: Register writes use `wdata_i[15]` as the set/clear flag. With bit 15 at 1, the ones in `wdata_i[14:0]` (enable) or `wdata_i[13:0]` (request) are set; with bit 15 at 0, they are cleared. `intreq_o` shows the request register one clock after the write, with no added delay.
- R3: A high bit of `src_i` sets the same request bit on the next edge. It wins over a clear write to that bit in the same cycle.
- R4: Pending = request AND enable[13:0], gated by master enable bit 14. The level is the highest group present: bits 0-2 give 1; bit 3 (ports) gives 2; bits 4-6 give 3; bits 7-11 give 4; bit 12 gives 5; bit 13 gives 6. `ipl_n_o` carries the inverted level and reflects the visible pending set of the previous clock.
- R5: With `pipe_len_i` = N > 0, a pending bit that rises because its request was newly set stays hidden from the pins until N `cck_i` ticks have passed.
- R6: A new rising bit while a hiding window runs joins the hidden set and restarts the window at N ticks, holding back the earlier bits too.
- R7: Clearing a request or an enable bit takes that bit off the pins one clock after the register changes, whether or not it is hidden.
- R8: Enabling the ports bit (3) while its request is already set shows it on the pins one clock later. Enabling any other already-set bit is hidden as in R5.
- R9: With `pipe_len_i` = 0, nothing is hidden, and the boundary decision uses the current pin level.
- R10: With N > 0, the pin level is latched whenever `bus_cyc_i` is high. A high `instr_bnd_i` raises `take_o` in that same cycle only if the last latched level is above `ipl_mask_i`. A level that appears after the last bus cycle is taken at a later boundary.
- R11: `take_lvl_o` gives the decided level while `take_o` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cck_i | input | 1 | Colour-clock tick enable |
| pipe_len_i | input | CNT_W | Hiding window length in ticks, 0 disables |
| src_i | input | 14 | Per-source assertion pulses |
| en_wr_i | input | 1 | Write strobe for the enable register |
| req_wr_i | input | 1 | Write strobe for the request register |
| wdata_i | input | 16 | Write data, bit 15 set/clear |
| bus_cyc_i | input | 1 | CPU bus cycle strobe, latches the pins |
| instr_bnd_i | input | 1 | CPU instruction boundary strobe |
| ipl_mask_i | input | 3 | CPU interrupt priority mask |
| ipl_n_o | output | 3 | Active-low priority level pins |
| intreq_o | output | 14 | Request register readback |
| take_o | output | 1 | Take-interrupt decision |
| take_lvl_o | output | 3 | Level being taken |

## Verification
A stale hidden-bit mask or a countdown that does not restart makes the pins reach their level one or more ticks early or late after a source pulse. A bad previous-pending copy either lets an unmasked port bit through late or hides an acknowledge. These timing errors show up on `ipl_n_o` within N+2 clocks of the stimulus. The bench therefore compares the pins every cycle against a model of the requirements. A wrong latched level in the sampler only shows at the next boundary strobe, as a missing or extra `take_o`.

// File: rtl/irq_ipl_pkg.sv
package irq_ipl_pkg;
  localparam int unsigned NSRC     = 14;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned PORT_BIT = 3;
  localparam logic [NSRC-1:0] PORT_MASK = NSRC'(1) << PORT_BIT;

  // fixed source-to-level grouping
  function automatic logic [LVL_W-1:0] lvl_of(input logic [NSRC-1:0] p);
    logic [LVL_W-1:0] l;
    if (p[13])            l = 3'd6;
    else if (p[12])       l = 3'd5;
    else if (|p[11:7])    l = 3'd4;
    else if (|p[6:4])     l = 3'd3;
    else if (p[PORT_BIT]) l = 3'd2;
    else if (|p[2:0])     l = 3'd1;
    else                  l = 3'd0;
    return l;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ipl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_wr_i,
  input  logic            req_wr_i,
  input  logic [15:0]     wdata_i,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC:0]   en_o,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC:0]   en_q;
  logic [NSRC-1:0] req_q, wr_set, wr_clr;

  always_comb begin
    wr_set = (req_wr_i &&  wdata_i[15]) ? wdata_i[NSRC-1:0] : '0;
    wr_clr = (req_wr_i && !wdata_i[15]) ? wdata_i[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      req_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i[15] ? (en_q | wdata_i[NSRC:0]) : (en_q & ~wdata_i[NSRC:0]);
      // sources win over a same-cycle acknowledge
      req_q <= (req_q & ~wr_clr) | wr_set | src_i;
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;
endmodule

// File: rtl/irq_delay.sv
module irq_delay
  import irq_ipl_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cck_i,
  input  logic [CNT_W-1:0] pipe_len_i,
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  req_i,
  output logic [NSRC-1:0]  vis_o
);
  logic [NSRC-1:0]  prev_pend_q, prev_req_q, mask_q, mask_nxt, rise, add;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    rise = pend_i & ~prev_pend_q;
    // level-fed ports bit exposed by unmasking skips the window
    add  = rise & ~(prev_req_q & PORT_MASK);
    mask_nxt = mask_q & pend_i;
    cnt_nxt  = cnt_q;
    if (cck_i && cnt_q != '0) begin
      cnt_nxt = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) mask_nxt = '0;
    end
    if (add != '0) begin
      mask_nxt = mask_nxt | add;
      cnt_nxt  = pipe_len_i;
    end
    if (pipe_len_i == '0) begin
      mask_nxt = '0;
      cnt_nxt  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_pend_q <= '0;
      prev_req_q  <= '0;
      mask_q      <= '0;
      cnt_q       <= '0;
    end else begin
      prev_pend_q <= pend_i;
      prev_req_q  <= req_i;
      mask_q      <= mask_nxt;
      cnt_q       <= cnt_nxt;
    end
  end

  assign vis_o = pend_i & ~mask_nxt;
endmodule

// File: rtl/irq_pin_enc.sv
module irq_pin_enc
  import irq_ipl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  vis_i,
  output logic [LVL_W-1:0] ipl_n_o
);
  logic [LVL_W-1:0] ipl_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipl_n_q <= '1;
    else         ipl_n_q <= ~lvl_of(vis_i);
  end

  assign ipl_n_o = ipl_n_q;
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
  import irq_ipl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic [LVL_W-1:0] ipl_n_i,
  input  logic             bus_cyc_i,
  input  logic             instr_bnd_i,
  input  logic [LVL_W-1:0] ipl_mask_i,
  output logic             take_o,
  output logic [LVL_W-1:0] take_lvl_o
);
  logic [LVL_W-1:0] smp_q, dec_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        smp_q <= '0;
    else if (bus_cyc_i) smp_q <= ~ipl_n_i;
  end

  always_comb begin
    dec_lvl    = bypass_i ? ~ipl_n_i : smp_q;
    take_o     = instr_bnd_i && (dec_lvl > ipl_mask_i);
    take_lvl_o = take_o ? dec_lvl : '0;
  end
endmodule

// File: rtl/irq_ipl_pipe.sv
module irq_ipl_pipe
  import irq_ipl_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cck_i,
  input  logic [CNT_W-1:0] pipe_len_i,
  input  logic [13:0]      src_i,
  input  logic             en_wr_i,
  input  logic             req_wr_i,
  input  logic [15:0]      wdata_i,
  input  logic             bus_cyc_i,
  input  logic             instr_bnd_i,
  input  logic [2:0]       ipl_mask_i,
  output logic [2:0]       ipl_n_o,
  output logic [13:0]      intreq_o,
  output logic             take_o,
  output logic [2:0]       take_lvl_o
);
  logic [NSRC:0]   en_q;
  logic [NSRC-1:0] req_q, pend, vis;

  irq_regs u_regs (
    .clk_i, .rst_ni, .en_wr_i, .req_wr_i, .wdata_i, .src_i,
    .en_o(en_q), .req_o(req_q)
  );

  assign pend = req_q & en_q[NSRC-1:0] & {NSRC{en_q[NSRC]}};

  irq_delay #(.CNT_W(CNT_W)) u_delay (
    .clk_i, .rst_ni, .cck_i, .pipe_len_i,
    .pend_i(pend), .req_i(req_q), .vis_o(vis)
  );

  irq_pin_enc u_enc (.clk_i, .rst_ni, .vis_i(vis), .ipl_n_o);

  irq_sampler u_smp (
    .clk_i, .rst_ni, .bypass_i(pipe_len_i == '0), .ipl_n_i(ipl_n_o),
    .bus_cyc_i, .instr_bnd_i, .ipl_mask_i, .take_o, .take_lvl_o
  );

  assign intreq_o = req_q;
endmodule

// File: rtl/irq_ipl_pipe_chk.sv
module irq_ipl_pipe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [13:0] src_i,
  input logic [13:0] intreq_o,
  input logic [2:0]  ipl_n_o,
  input logic        en_master_i,
  input logic        pend_any_i,
  input logic        instr_bnd_i,
  input logic [2:0]  ipl_mask_i,
  input logic        take_o,
  input logic [2:0]  take_lvl_o
);
  a_r3_src_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((intreq_o & $past(src_i)) == $past(src_i)));

  a_r7_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_any_i |=> (ipl_n_o == 3'b111));

  a_r4_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_master_i |=> (ipl_n_o == 3'b111));

  a_r10_take_at_bnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> instr_bnd_i);

  a_r11_take_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (take_lvl_o > ipl_mask_i));

  a_r11_lvl_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (take_lvl_o == 3'd0));
endmodule

bind irq_ipl_pipe irq_ipl_pipe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .intreq_o(intreq_o),
  .ipl_n_o(ipl_n_o), .en_master_i(en_q[14]), .pend_any_i(|pend),
  .instr_bnd_i(instr_bnd_i), .ipl_mask_i(ipl_mask_i), .take_o(take_o),
  .take_lvl_o(take_lvl_o)
);

// File: tb/irq_ipl_pipe_bench.sv
module irq_ipl_pipe_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, cck = 1'b1;
  logic [3:0]  pipe_len = 4'd5;
  logic [13:0] src = '0;
  logic        en_wr = 1'b0, req_wr = 1'b0, bus_cyc = 1'b0, bnd = 1'b0;
  logic [15:0] wdata = '0;
  logic [2:0]  ipl_mask = 3'd0;
  logic [2:0]  ipl_n, take_lvl;
  logic [13:0] intreq;
  logic        take;

  int checks = 0, fails = 0;
  logic        last_take;
  logic [2:0]  last_lvl;

  // model state
  logic [14:0] m_en = '0;
  logic [13:0] m_req = '0, m_ppend = '0, m_preq = '0, m_mask = '0;
  int          m_cnt = 0;
  logic [2:0]  m_lvl = '0, m_smp = '0;

  always #5 clk = ~clk;

  irq_ipl_pipe u_irq_ipl_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .cck_i(cck), .pipe_len_i(pipe_len), .src_i(src),
    .en_wr_i(en_wr), .req_wr_i(req_wr), .wdata_i(wdata), .bus_cyc_i(bus_cyc),
    .instr_bnd_i(bnd), .ipl_mask_i(ipl_mask), .ipl_n_o(ipl_n), .intreq_o(intreq),
    .take_o(take), .take_lvl_o(take_lvl)
  );

  function automatic int grp(int i);
    if (i <= 2) return 1;
    if (i == 3) return 2;
    if (i <= 6) return 3;
    if (i <= 11) return 4;
    if (i == 12) return 5;
    return 6;
  endfunction

  function automatic logic [2:0] ref_lvl(logic [13:0] p);
    int best = 0;
    for (int i = 0; i < 14; i++) if (p[i] && grp(i) > best) best = grp(i);
    return 3'(best);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [13:0] pend, add, nm;
    int nc;
    pend = m_req & m_en[13:0] & {14{m_en[14]}};
    add  = pend & ~m_ppend;
    if (m_preq[3]) add[3] = 1'b0;
    nm = m_mask & pend;
    nc = m_cnt;
    if (cck && m_cnt > 0) begin nc = m_cnt - 1; if (nc == 0) nm = '0; end
    if (add != '0) begin nm = nm | add; nc = int'(pipe_len); end
    if (pipe_len == 0) begin nm = '0; nc = 0; end
    if (bus_cyc) m_smp = m_lvl;
    m_lvl   = ref_lvl(pend & ~nm);
    m_ppend = pend;
    m_preq  = m_req;
    m_mask  = nm;
    m_cnt   = nc;
    if (en_wr) m_en = wdata[15] ? (m_en | wdata[14:0]) : (m_en & ~wdata[14:0]);
    if (req_wr) m_req = wdata[15] ? (m_req | wdata[13:0]) : (m_req & ~wdata[13:0]);
    m_req = m_req | src;
  endtask

  // inputs are applied at a falling edge before the call
  task automatic cyc();
    logic [2:0] dec;
    logic       et;
    #1;
    dec = (pipe_len == 0) ? m_lvl : m_smp;
    et  = bnd && (dec > ipl_mask);
    chk("R10 take", {31'd0, take}, {31'd0, et});
    chk("R11 take level", {29'd0, take_lvl}, {29'd0, et ? dec : 3'd0});
    last_take = take;
    last_lvl  = take_lvl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 pins", {29'd0, ipl_n}, {29'd0, ~m_lvl});
    chk("R2 readback", {18'd0, intreq}, {18'd0, m_req});
    src = '0; en_wr = 1'b0; req_wr = 1'b0; bus_cyc = 1'b0; bnd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic clear_all();
    en_wr = 1'b1; req_wr = 1'b1; wdata = 16'h7FFF; cyc();
    idle(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {29'd0, ipl_n}, 32'h7);
    chk("R1 reset req", {18'd0, intreq}, 32'h0);
    chk("R1 reset take", {31'd0, take}, 32'h0);
    rst_ni = 1'b1;
    idle(2);

    // R5: vertical blank source hidden for five ticks
    en_wr = 1'b1; wdata = 16'hC020; cyc();
    src = 14'h0020; cyc();
    chk("R2 undelayed readback", {18'd0, intreq}, 32'h0020);
    for (int k = 2; k <= 7; k++) begin
      cyc();
      if (k == 6) chk("R5 still hidden", {29'd0, ipl_n}, 32'h7);
      if (k == 7) chk("R5 shown after window", {29'd0, ipl_n}, 32'h4);
    end
    // R7: acknowledge
    req_wr = 1'b1; wdata = 16'h0020; cyc();
    cyc();
    chk("R7 ack reaches pins", {29'd0, ipl_n}, 32'h7);

    // R3: source beats clear
    src = 14'h0002; req_wr = 1'b1; wdata = 16'h0002; cyc();
    chk("R3 source wins", {31'd0, intreq[1]}, 32'h1);
    clear_all();

    // R8: ports bit unmasked while latched
    en_wr = 1'b1; wdata = 16'hC000; cyc();
    src = 14'h0008; cyc();
    idle(8);
    chk("R8 masked port", {29'd0, ipl_n}, 32'h7);
    en_wr = 1'b1; wdata = 16'h8008; cyc();
    cyc();
    chk("R8 port immediate", {29'd0, ipl_n}, 32'h5);
    en_wr = 1'b1; req_wr = 1'b1; wdata = 16'h0008; cyc();
    src = 14'h2000; cyc();
    idle(8);
    en_wr = 1'b1; wdata = 16'hA000; cyc();
    for (int k = 2; k <= 7; k++) begin
      cyc();
      if (k == 2) chk("R8 other source hidden", {29'd0, ipl_n}, 32'h7);
      if (k == 7) chk("R8 other source shown", {29'd0, ipl_n}, 32'h1);
    end
    clear_all();

    // R6: second rise restarts window
    en_wr = 1'b1; wdata = 16'hD010; cyc();
    src = 14'h0010; cyc();
    for (int k = 2; k <= 10; k++) begin
      if (k == 4) src = 14'h1000;
      cyc();
      if (k == 7) chk("R6 first bit held by restart", {29'd0, ipl_n}, 32'h7);
      if (k == 9) chk("R6 still held", {29'd0, ipl_n}, 32'h7);
      if (k == 10) chk("R6 released together", {29'd0, ipl_n}, 32'h2);
    end
    clear_all();

    // R10: level after last bus cycle is taken one instruction later
    ipl_mask = 3'd2;
    bus_cyc = 1'b1; cyc();
    en_wr = 1'b1; wdata = 16'hC010; cyc();
    src = 14'h0010; cyc();
    idle(6);
    chk("R10 pins at level 3", {29'd0, ipl_n}, 32'h4);
    bnd = 1'b1; cyc();
    chk("R10 no take on stale sample", {31'd0, last_take}, 32'h0);
    bus_cyc = 1'b1; cyc();
    bnd = 1'b1; cyc();
    chk("R10 take after bus cycle", {31'd0, last_take}, 32'h1);
    chk("R11 level 3", {29'd0, last_lvl}, 32'h3);
    ipl_mask = 3'd3; bnd = 1'b1; cyc();
    chk("R10 masked level", {31'd0, last_take}, 32'h0);
    clear_all();

    // R9: zero length, immediate pins and live decision
    pipe_len = 4'd0; ipl_mask = 3'd0;
    bus_cyc = 1'b1; cyc();
    en_wr = 1'b1; wdata = 16'hC081; cyc();
    src = 14'h0001; cyc();
    cyc();
    chk("R9 immediate level 1", {29'd0, ipl_n}, 32'h6);
    src = 14'h0080; cyc();
    cyc();
    chk("R9 R4 level 4", {29'd0, ipl_n}, 32'h3);
    bnd = 1'b1; cyc();
    chk("R9 live decision", {31'd0, last_take}, 32'h1);
    clear_all();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 3) begin
        case ($urandom_range(0, 3))
          0: pipe_len = 4'd0;
          1: pipe_len = 4'd1;
          2: pipe_len = 4'd2;
          default: pipe_len = 4'd5;
        endcase
      end
      cck = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 3) == 0) src = 14'(1 << $urandom_range(0, 13));
      if ($urandom_range(0, 9) == 0) begin
        en_wr = 1'b1;
        wdata = {1'($urandom_range(0, 2) != 0), 15'($urandom)};
      end else if ($urandom_range(0, 7) == 0) begin
        req_wr = 1'b1;
        wdata = {1'($urandom_range(0, 3) == 0), 15'($urandom)};
      end
      bus_cyc  = 1'($urandom_range(0, 1));
      bnd      = ($urandom_range(0, 3) == 0);
      ipl_mask = 3'($urandom_range(0, 6));
      cyc();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule